// File: doc/BRIEF.md
# Power Cap Hysteresis Throttle Controller

This block keeps a system's power draw under a user-set cap by stepping a discrete throttle level. On every poll strobe it compares the latest power reading against two thresholds computed from the cap: an upper trip point set a programmable margin below the cap, and a lower release point set a further programmable gap below that. Power above the upper point raises the throttle by one step. Power below the lower point lowers it by one step. Power in the band between them leaves it unchanged. Because the block acts only on polls, a brief excursion above the cap is tolerated until the next poll responds to it.

Each change is announced on a one-cycle request strobe to an external throttle actuator, which answers with an acknowledge once the change has taken effect. Until that acknowledge arrives, the next poll does not take a new step. It repeats the outstanding request at the same level. When capping is disabled, the block drops the throttle to zero. How a level maps onto processor or memory limits is left to the actuator. The cap is expected to lie between the system's minimum and maximum possible consumption.

Top module: `pcap_throttle`

## Requirements
- R1: After reset, `thr_level` is 0 and `thr_req` is 0.
- R2: The upper threshold is `cap_value - cap_margin` and the lower threshold is the upper threshold minus `band_gap`. Each subtraction stops at 0 rather than wrapping.
- R3: On a poll with `cap_en` high and no outstanding request, power strictly above the upper threshold raises `thr_level` by one. `thr_level` and a one-cycle `thr_req` pulse appear in the cycle after the poll.
- R4: On such a poll, power strictly below the lower threshold lowers `thr_level` by one and pulses `thr_req`.
- R5: On such a poll, power from the lower threshold up to the upper threshold, both ends included, leaves `thr_level` unchanged and gives no `thr_req`.
- R6: `thr_level` never exceeds MAX_LEVEL (default 7) and never goes below 0. A step past either end produces no change and no `thr_req`.
- R7: A request stays outstanding from its `thr_req` until an `act_ack` pulse, which may arrive in any cycle up to and including the next poll cycle. An enabled poll that finds a request outstanding pulses `thr_req` again and keeps `thr_level` unchanged, whatever the power.
- R8: A poll with `cap_en` low sets `thr_level` to 0. It pulses `thr_req` only if the level was nonzero. It also discards any outstanding request.
- R9: Outputs change only in the cycle after a poll. Between polls, power, cap and settings have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll | input | 1 | One-cycle strobe that starts an evaluation |
| cap_en | input | 1 | Power capping enable |
| pwr_meas | input | PW (12) | Measured system power |
| cap_value | input | PW (12) | User power cap |
| cap_margin | input | PW (12) | Distance of the upper threshold below the cap |
| band_gap | input | PW (12) | Distance of the lower threshold below the upper one |
| act_ack | input | 1 | Actuator confirms the last requested level took effect |
| thr_level | output | LW (3) | Current throttle level, 0 = unthrottled |
| thr_req | output | 1 | One-cycle strobe announcing a new or reissued level |

## Verification
The assertions assume that `poll` is a single-cycle strobe, that `act_ack` arrives only after a `thr_req`, and that the inputs are valid from the first cycle after reset. The bench drives every input on the falling edge and raises `poll` for exactly one cycle at a time. It sends each acknowledge as one pulse after the request it answers, and it holds all inputs at defined values from time zero. Retry cases are built by leaving an acknowledge out.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    // Action chosen for one poll
    typedef enum logic [2:0] {
        ACT_HOLD    = 3'd0,
        ACT_UP      = 3'd1,
        ACT_DOWN    = 3'd2,
        ACT_RETRY   = 3'd3,
        ACT_RELEASE = 3'd4
    } act_e;

    // Verdict carried from decision to state update
    typedef struct packed {
        act_e act;
        logic fire;   // a request strobe must be issued
    } verdict_t;

endpackage

// File: rtl/pcap_thresh.sv
module pcap_thresh #(
    parameter int PW = 12
) (
    input  logic [PW-1:0] cap_value,
    input  logic [PW-1:0] cap_margin,
    input  logic [PW-1:0] band_gap,
    output logic [PW-1:0] thr_hi,
    output logic [PW-1:0] thr_lo
);

    // Subtraction that stops at zero
    function automatic logic [PW-1:0] floor_sub(input logic [PW-1:0] a, input logic [PW-1:0] b);
        return (a > b) ? (a - b) : '0;
    endfunction

    always_comb begin
        thr_hi = floor_sub(cap_value, cap_margin);
        thr_lo = floor_sub(thr_hi, band_gap);
    end

endmodule

// File: rtl/pcap_decide.sv
module pcap_decide
    import pcap_pkg::*;
#(
    parameter int PW        = 12,
    parameter int MAX_LEVEL = 7,
    parameter int LW        = 3
) (
    input  logic          poll,
    input  logic          cap_en,
    input  logic          outstanding,
    input  logic [PW-1:0] pwr_meas,
    input  logic [PW-1:0] thr_hi,
    input  logic [PW-1:0] thr_lo,
    input  logic [LW-1:0] level,
    output verdict_t      verdict
);

    localparam logic [LW-1:0] TOP = LW'(MAX_LEVEL);

    always_comb begin
        verdict = '{act: ACT_HOLD, fire: 1'b0};
        if (poll) begin
            if (!cap_en) begin
                if (level != '0) verdict = '{act: ACT_RELEASE, fire: 1'b1};
            end else if (outstanding) begin
                verdict = '{act: ACT_RETRY, fire: 1'b1};
            end else if (pwr_meas > thr_hi) begin
                if (level != TOP) verdict = '{act: ACT_UP, fire: 1'b1};
            end else if (pwr_meas < thr_lo) begin
                if (level != '0) verdict = '{act: ACT_DOWN, fire: 1'b1};
            end
        end
    end

endmodule

// File: rtl/pcap_throttle.sv
module pcap_throttle
    import pcap_pkg::*;
#(
    parameter int PW        = 12,
    parameter int MAX_LEVEL = 7,
    localparam int LW       = $clog2(MAX_LEVEL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          poll,
    input  logic          cap_en,
    input  logic [PW-1:0] pwr_meas,
    input  logic [PW-1:0] cap_value,
    input  logic [PW-1:0] cap_margin,
    input  logic [PW-1:0] band_gap,
    input  logic          act_ack,
    output logic [LW-1:0] thr_level,
    output logic          thr_req
);

    logic [PW-1:0] thr_hi, thr_lo;
    logic          pending;
    logic          outstanding;
    verdict_t      verdict;

    pcap_thresh #(.PW(PW)) u_thresh (
        .cap_value (cap_value),
        .cap_margin(cap_margin),
        .band_gap  (band_gap),
        .thr_hi    (thr_hi),
        .thr_lo    (thr_lo)
    );

    // An acknowledge in the poll cycle itself clears the request in time
    assign outstanding = pending && !act_ack;

    pcap_decide #(.PW(PW), .MAX_LEVEL(MAX_LEVEL), .LW(LW)) u_decide (
        .poll       (poll),
        .cap_en     (cap_en),
        .outstanding(outstanding),
        .pwr_meas   (pwr_meas),
        .thr_hi     (thr_hi),
        .thr_lo     (thr_lo),
        .level      (thr_level),
        .verdict    (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_level <= '0;
            thr_req   <= 1'b0;
            pending   <= 1'b0;
        end else begin
            thr_req <= verdict.fire;
            if (act_ack) pending <= 1'b0;
            if (poll && !cap_en) pending <= 1'b0;
            unique case (verdict.act)
                ACT_UP:      begin thr_level <= thr_level + 1'b1; pending <= 1'b1; end
                ACT_DOWN:    begin thr_level <= thr_level - 1'b1; pending <= 1'b1; end
                ACT_RETRY:   pending <= 1'b1;
                ACT_RELEASE: thr_level <= '0;
                default:     ;
            endcase
        end
    end

    // Strobe appears only in the cycle after a poll (R9)
    assert_req_after_poll_R9: assert property (@(posedge clk) disable iff (rst)
        thr_req |-> $past(poll));

    // Level moves only together with a request strobe (R9)
    assert_move_with_req_R9: assert property (@(posedge clk) disable iff (rst)
        (thr_level != $past(thr_level)) |-> thr_req);

    // Enabled steps are single (R3, R4)
    assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(cap_en) && thr_level != $past(thr_level)) |->
        (thr_level == $past(thr_level) + LW'(1) || thr_level == $past(thr_level) - LW'(1)));

    // Level stays in range (R6)
    assert_level_range_R6: assert property (@(posedge clk) disable iff (rst)
        thr_level <= LW'(MAX_LEVEL));

    // Unacknowledged request is reissued at the same level (R7)
    assert_retry_same_R7: assert property (@(posedge clk) disable iff (rst)
        $past(poll && cap_en && pending && !act_ack) |-> (thr_req && $stable(thr_level)));

    // Disabled poll clears the level (R8)
    assert_release_zero_R8: assert property (@(posedge clk) disable iff (rst)
        $past(poll && !cap_en) |-> (thr_level == '0));

endmodule

// File: tb/sim_pcap_throttle.sv
module sim_pcap_throttle;

    localparam int PW = 12;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          poll = 1'b0;
    logic          cap_en = 1'b1;
    logic [PW-1:0] pwr_meas = '0;
    logic [PW-1:0] cap_value = 12'd1000;
    logic [PW-1:0] cap_margin = 12'd100;
    logic [PW-1:0] band_gap = 12'd200;
    logic          act_ack = 1'b0;
    logic [LW-1:0] thr_level;
    logic          thr_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pcap_throttle #(.PW(PW), .MAX_LEVEL(7)) u0 (
        .clk(clk), .rst(rst), .poll(poll), .cap_en(cap_en),
        .pwr_meas(pwr_meas), .cap_value(cap_value), .cap_margin(cap_margin),
        .band_gap(band_gap), .act_ack(act_ack),
        .thr_level(thr_level), .thr_req(thr_req)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // One poll; sample outputs on the falling edge after the capturing edge
    task automatic poll_at(input int pwr, input string tag, input int exp_lvl, input int exp_req);
        @(negedge clk);
        pwr_meas = PW'(pwr);
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
        check({tag, " level"}, int'(thr_level), exp_lvl);
        check({tag, " req"}, int'(thr_req), exp_req);
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        act_ack = 1'b1;
        @(negedge clk);
        act_ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset level", int'(thr_level), 0);
        check("R1 reset req", int'(thr_req), 0);
    endtask

    task automatic t_no_poll();
        @(negedge clk);
        pwr_meas = 12'd2000;
        cap_value = 12'd10;
        repeat (5) @(negedge clk);
        check("R9 idle level", int'(thr_level), 0);
        check("R9 idle req", int'(thr_req), 0);
        cap_value = 12'd1000;
    endtask

    task automatic t_rise_and_band();
        poll_at(950, "R3 up1", 1, 1);
        @(negedge clk);
        check("R3 req one cycle", int'(thr_req), 0);
        ack_pulse();
        poll_at(901, "R3 up2", 2, 1);
        ack_pulse();
        poll_at(900, "R5 at hi", 2, 0);
        poll_at(700, "R5 at lo", 2, 0);
    endtask

    task automatic t_fall();
        poll_at(699, "R4 down", 1, 1);
        ack_pulse();
    endtask

    task automatic t_retry();
        poll_at(950, "R7 step", 2, 1);
        poll_at(100, "R7 reissue", 2, 1);
        poll_at(100, "R7 reissue again", 2, 1);
        ack_pulse();
        poll_at(950, "R7 after ack", 3, 1);
        // acknowledge in the same cycle as the poll
        @(negedge clk);
        pwr_meas = 12'd950;
        poll = 1'b1;
        act_ack = 1'b1;
        @(negedge clk);
        poll = 1'b0;
        act_ack = 1'b0;
        check("R7 same-cycle ack level", int'(thr_level), 4);
        check("R7 same-cycle ack req", int'(thr_req), 1);
        ack_pulse();
    endtask

    task automatic t_top();
        for (int l = 5; l <= 7; l++) begin
            poll_at(950, "R6 climb", l, 1);
            ack_pulse();
        end
        poll_at(950, "R6 top sat", 7, 0);
    endtask

    task automatic t_bottom();
        for (int l = 6; l >= 0; l--) begin
            poll_at(0, "R6 descend", l, 1);
            ack_pulse();
        end
        poll_at(0, "R6 bottom sat", 0, 0);
    endtask

    task automatic t_floor();
        // hi = 50-100 -> 0, lo -> 0
        cap_value = 12'd50;
        cap_margin = 12'd100;
        band_gap = 12'd10;
        poll_at(0, "R2 floored hold", 0, 0);
        poll_at(1, "R2 floored up", 1, 1);
        ack_pulse();
        // hi = 900, lo = 900-2000 -> 0
        cap_value = 12'd1000;
        band_gap = 12'd2000;
        poll_at(0, "R2 lo floored hold", 1, 0);
        band_gap = 12'd200;
    endtask

    task automatic t_disable();
        poll_at(950, "R8 prep", 2, 1);
        cap_en = 1'b0;
        poll_at(950, "R8 release", 0, 1);
        poll_at(950, "R8 quiet", 0, 0);
        cap_en = 1'b1;
        poll_at(800, "R8 pending dropped", 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_poll();
        t_rise_and_band();
        t_fall();
        t_retry();
        t_top();
        t_bottom();
        t_floor();
        t_disable();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule